// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block forms 20-bit physical byte addresses from a segment base and a 16-bit offset, as done by a processor running in real mode. It holds six 16-bit segment base registers. The physical address is the chosen base multiplied by sixteen plus the offset, and the result is truncated to 20 bits. An address request carries an access kind: instruction fetch, stack access, ordinary data, or string destination. The access kind chooses the segment implicitly. An explicit override can replace that choice.

Software-visible loads arrive through a single load port. The code segment base is the exception. It comes only from its reset value, and the load port refuses it. An attempt to load it, or to load an index that names no register, raises a one-cycle error flag and changes no register. The address path is purely combinational. A load becomes visible after the next rising clock edge.

Top module: `seg_addr_gen`

## Requirements
- R1: After reset the code segment holds CS_RST (default FFFFh) and the other five segment registers hold 0000h.
- R2: addr_o equals (selected segment value x 16 + offset_i), for example segment 1000h with offset 1F00h gives 11F00h.
- R3: A sum above FFFFFh wraps modulo 2^20, for example segment FFFFh with offset FFFFh gives 0FFEFh.
- R4: With no override, access kind 0 (instruction fetch) uses the code segment.
- R5: With no override, access kind 1 (stack) uses the stack segment.
- R6: With no override, access kind 2 (data) uses the data segment.
- R7: With no override, access kind 3 (string destination) uses the extra segment.
- R8: When ovr_en_i is high, ovr_sel_i picks the segment: 0 extra, 1 code, 2 stack, 3 data, 4 first additional, 5 second additional. The codes 6 and 7 pick the data segment. The access kind is then ignored.
- R9: A load with ld_en_i high writes ld_val_i into the register named by ld_sel_i (same code as R8). The new value appears on addr_o after the next rising edge and not before it.
- R10: A load naming code 1, 6 or 7 changes no register and drives ld_err_o high for the cycle after that edge.
- R11: ld_err_o is low after reset and after any edge without a refused load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_en_i | input | 1 | Segment load strobe |
| ld_sel_i | input | 3 | Register to load |
| ld_val_i | input | 16 | Value to load |
| ld_err_o | output | 1 | Refused load in the previous cycle |
| acc_i | input | 2 | Access kind for the request |
| ovr_en_i | input | 1 | Segment override valid |
| ovr_sel_i | input | 3 | Override segment code |
| offset_i | input | 16 | Offset within the segment |
| addr_o | output | 20 | Physical address |

## Verification
The bench loads each writable register with a distinct value. It sweeps every override code and every access kind against offsets at 0, 1, mid-range and FFFFh. A wrong mapping from access kind or override to segment shows up as the address of a different register. The wrap cases use bases FFFFh and F000h. An adder carrying out of bit 19 would produce an address of 100000h or above, truncated wrongly or saturated. Refused loads of the code segment and of the unused codes 6 and 7 are each followed by a readback of every register. This catches a design that still writes, or that writes some neighbour. The readback before the load edge shows whether the load is applied too early.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int unsigned NUM_SEG = 6;
  localparam int unsigned SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    SEG_ES = 3'd0,
    SEG_CS = 3'd1,
    SEG_SS = 3'd2,
    SEG_DS = 3'd3,
    SEG_FS = 3'd4,
    SEG_GS = 3'd5
  } seg_id_e;

  typedef enum logic [1:0] {
    ACC_FETCH   = 2'd0,
    ACC_STACK   = 2'd1,
    ACC_DATA    = 2'd2,
    ACC_STR_DST = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W  = 16,
  parameter logic [SEG_W-1:0] CS_RST = '1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              ld_en_i,
  input  logic [SEL_W-1:0]                  ld_sel_i,
  input  logic [SEG_W-1:0]                  ld_val_i,
  output logic [NUM_SEG-1:0][SEG_W-1:0]     seg_o,
  output logic                              ld_err_o
);
  logic bad_sel;
  assign bad_sel = (ld_sel_i == SEG_CS) || (32'(ld_sel_i) >= NUM_SEG);

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic [SEG_W-1:0] q;
    if (g == int'(SEG_CS)) begin : g_code
      // code base is fixed after reset; only the reset value reaches it
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= CS_RST;
        else         q <= q;
      end
    end else begin : g_data
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                     q <= '0;
        else if (ld_en_i && 32'(ld_sel_i) == g)          q <= ld_val_i;
      end
    end
    assign seg_o[g] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ld_err_o <= 1'b0;
    else         ld_err_o <= ld_en_i && bad_sel;
  end

  p_cs_fixed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(seg_o[SEG_CS]));
  p_refused_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_en_i && bad_sel |=> ld_err_o);
  p_err_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_en_i |=> !ld_err_o);
  p_ds_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_en_i && ld_sel_i == SEG_DS |=> seg_o[SEG_DS] == $past(ld_val_i));
endmodule

// File: rtl/seg_select.sv
module seg_select
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W = 16
) (
  input  logic [1:0]                    acc_i,
  input  logic                          ovr_en_i,
  input  logic [SEL_W-1:0]              ovr_sel_i,
  input  logic [NUM_SEG-1:0][SEG_W-1:0] seg_i,
  output logic [SEG_W-1:0]              seg_val_o
);
  seg_id_e implicit_id, pick_id;

  always_comb begin
    unique case (acc_kind_e'(acc_i))
      ACC_FETCH:   implicit_id = SEG_CS;
      ACC_STACK:   implicit_id = SEG_SS;
      ACC_DATA:    implicit_id = SEG_DS;
      ACC_STR_DST: implicit_id = SEG_ES;
      default:     implicit_id = SEG_DS;
    endcase
  end

  always_comb begin
    if (!ovr_en_i)                         pick_id = implicit_id;
    else if (32'(ovr_sel_i) >= NUM_SEG)    pick_id = SEG_DS;
    else                                   pick_id = seg_id_e'(ovr_sel_i);
  end

  assign seg_val_o = seg_i[pick_id];
endmodule

// File: rtl/addr_adder.sv
module addr_adder #(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned SHIFT  = 4,
  parameter int unsigned ADDR_W = 20
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned BASE_W = SEG_W + SHIFT;
  localparam int unsigned EXT_W  = ((BASE_W > OFF_W) ? BASE_W : OFF_W) + 1;

  logic [EXT_W-1:0] sum;
  assign sum    = (EXT_W'(seg_i) << SHIFT) + EXT_W'(off_i);
  // carry out of the top address bit is dropped: modulo 2^ADDR_W
  assign addr_o = sum[ADDR_W-1:0];
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int unsigned SEG_W  = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned SHIFT  = 4,
  parameter int unsigned ADDR_W = 20,
  parameter logic [SEG_W-1:0] CS_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_en_i,
  input  logic [2:0]        ld_sel_i,
  input  logic [SEG_W-1:0]  ld_val_i,
  output logic              ld_err_o,
  input  logic [1:0]        acc_i,
  input  logic              ovr_en_i,
  input  logic [2:0]        ovr_sel_i,
  input  logic [OFF_W-1:0]  offset_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [NUM_SEG-1:0][SEG_W-1:0] seg_q;
  logic [SEG_W-1:0]              seg_val;

  seg_regfile #(.SEG_W(SEG_W), .CS_RST(CS_RST)) u_regs (
    .clk_i, .rst_ni, .ld_en_i, .ld_sel_i, .ld_val_i,
    .seg_o(seg_q), .ld_err_o
  );

  seg_select #(.SEG_W(SEG_W)) u_sel (
    .acc_i, .ovr_en_i, .ovr_sel_i, .seg_i(seg_q), .seg_val_o(seg_val)
  );

  addr_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_add (
    .seg_i(seg_val), .off_i(offset_i), .addr_o
  );

  p_low_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o[SHIFT-1:0] == offset_i[SHIFT-1:0]);
  p_fetch_cs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovr_en_i && acc_i == ACC_FETCH |-> seg_val == seg_q[SEG_CS]);
  p_stack_ss_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovr_en_i && acc_i == ACC_STACK |-> seg_val == seg_q[SEG_SS]);
  p_strdst_es_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovr_en_i && acc_i == ACC_STR_DST |-> seg_val == seg_q[SEG_ES]);
  p_override_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_en_i && ovr_sel_i == SEG_GS |-> seg_val == seg_q[SEG_GS]);
endmodule

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_en_i = 1'b0;
  logic [2:0]  ld_sel_i = '0;
  logic [15:0] ld_val_i = '0;
  logic        ld_err_o;
  logic [1:0]  acc_i = '0;
  logic        ovr_en_i = 1'b0;
  logic [2:0]  ovr_sel_i = '0;
  logic [15:0] offset_i = '0;
  logic [19:0] addr_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model [6];
  bit done = 1'b0;

  always #5 clk = ~clk;

  seg_addr_gen u0 (.clk_i(clk), .rst_ni, .ld_en_i, .ld_sel_i, .ld_val_i, .ld_err_o,
                   .acc_i, .ovr_en_i, .ovr_sel_i, .offset_i, .addr_o);

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    logic [20:0] t;
    t = {1'b0, s, 4'h0} + {5'h0, o};
    return t[19:0];
  endfunction

  task automatic chk(input string req, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%05h expected=%05h", req, act, exp);
    end
  endtask

  task automatic req(input string r, input logic [1:0] a, input logic oe,
                     input logic [2:0] os, input logic [15:0] off, input logic [19:0] exp);
    acc_i = a; ovr_en_i = oe; ovr_sel_i = os; offset_i = off;
    #1;
    chk(r, addr_o, exp);
  endtask

  task automatic readback_all(input string r);
    for (int k = 0; k < 6; k++) req(r, 2'd2, 1'b1, 3'(k), 16'h0005, phys(model[k], 16'h0005));
  endtask

  // drive at negedge, edge applies, sample at following negedge
  task automatic load(input logic [2:0] sel, input logic [15:0] val, input logic exp_err);
    @(negedge clk);
    ld_en_i = 1'b1; ld_sel_i = sel; ld_val_i = val;
    #1;
    if (sel != 3'd1 && sel < 3'd6)
      req("R9", 2'd2, 1'b1, sel, 16'h0000, phys(model[sel], 16'h0000));
    @(negedge clk);
    ld_en_i = 1'b0;
    if (sel != 3'd1 && sel < 3'd6) model[sel] = val;
    chk(exp_err ? "R10" : "R11", 20'(ld_err_o), 20'(exp_err));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model[0] = 16'h0000; model[1] = 16'hFFFF; model[2] = 16'h0000;
    model[3] = 16'h0000; model[4] = 16'h0000; model[5] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int k = 0; k < 6; k++) req("R1", 2'd0, 1'b1, 3'(k), 16'h0000, phys(model[k], 16'h0000));
    chk("R11", 20'(ld_err_o), 20'h0);

    // R9 loads of writable registers
    load(3'd0, 16'h2000, 1'b0);
    load(3'd2, 16'h3A51, 1'b0);
    load(3'd3, 16'h1000, 1'b0);
    load(3'd4, 16'h7C0D, 1'b0);
    load(3'd5, 16'hB0E3, 1'b0);

    req("R2", 2'd2, 1'b0, 3'd0, 16'h1F00, 20'h11F00);

    // R8 override sweep incl. unused codes
    for (int k = 0; k < 8; k++) begin
      for (int j = 0; j < 5; j++) begin
        logic [15:0] off;
        logic [2:0] eff;
        off = (j == 0) ? 16'h0000 : (j == 1) ? 16'h0001 : (j == 2) ? 16'h8000 :
              (j == 3) ? 16'h1F00 : 16'hFFFF;
        eff = (k >= 6) ? 3'd3 : 3'(k);
        for (int a = 0; a < 4; a++) req("R8", 2'(a), 1'b1, 3'(k), off, phys(model[eff], off));
      end
    end

    // R4-R7 implicit selection sweep
    for (int j = 0; j < 16; j++) begin
      logic [15:0] off;
      off = 16'(j * 16'h1111);
      req("R4", 2'd0, 1'b0, 3'd5, off, phys(model[1], off));
      req("R5", 2'd1, 1'b0, 3'd4, off, phys(model[2], off));
      req("R6", 2'd2, 1'b0, 3'd0, off, phys(model[3], off));
      req("R7", 2'd3, 1'b0, 3'd2, off, phys(model[0], off));
    end

    // R3 wrap
    req("R3", 2'd0, 1'b0, 3'd0, 16'h0010, 20'h00000);
    req("R3", 2'd0, 1'b0, 3'd0, 16'hFFFF, 20'h0FFEF);
    load(3'd2, 16'hFFFF, 1'b0);
    req("R3", 2'd1, 1'b0, 3'd0, 16'hFFFF, 20'h0FFEF);
    load(3'd3, 16'hF000, 1'b0);
    req("R3", 2'd2, 1'b0, 3'd0, 16'hFFFF, 20'hFFFFF);
    load(3'd0, 16'hF800, 1'b0);
    req("R3", 2'd3, 1'b0, 3'd0, 16'hA000, 20'h02000);

    // R10 refused loads
    load(3'd1, 16'h1234, 1'b1);
    readback_all("R10");
    load(3'd6, 16'h4321, 1'b1);
    readback_all("R10");
    load(3'd7, 16'h5555, 1'b1);
    readback_all("R10");
    // R11 flag drops on the next edge
    @(negedge clk);
    chk("R11", 20'(ld_err_o), 20'h0);
    load(3'd4, 16'h0001, 1'b0);
    readback_all("R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule